// File: doc/BRIEF.md
# Rank-Ordered LRU Tracker for a Set-Associative Cache

This block keeps an exact least-recently-used order for every set of a set-associative cache. It holds four ways by default. Each way of a set carries a small recency rank. The highest rank marks the way used most recently, and rank zero marks the way left unused longest. The ranks of one set always form a permutation of 0 to WAYS-1. The cache controller reports each access as a touch, naming the set and the way. The tracker then reorders that set's ranks so that the touched way becomes the newest. The others close ranks behind it.

A separate query port names a set. It returns that set's current ranks and the way to replace there. The replacement choice is normally the way of rank zero. An optional mask of invalid ways can take precedence over it, and the lowest-numbered empty way then wins. A synchronous clear puts every set back to its starting order. The query port reads stored state. A touch therefore becomes visible one cycle after it is presented, and a query in the same cycle sees the old order.

Top module: `lru_rank_tracker`

## Requirements
- R1: While reset is asserted and after reset, every set holds rank w in way w. On `query_ranks_o`, way w's rank occupies bits [RANK_W*w+RANK_W-1 : RANK_W*w], which is 8'hE4 for four ways.
- R2: A cycle with `clear_i` high returns every set to the R1 order from the next cycle on. Clear takes precedence over a touch presented in the same cycle.
- R3: Touching a way whose rank is already WAYS-1 leaves all ranks of that set unchanged.
- R4: Touching a way of rank r < WAYS-1 has three effects from the next cycle on: that way has rank WAYS-1, every way of the set with a rank above r loses one, and ways with a rank below r keep theirs.
- R5: A touch changes only the set named by `touch_set_i`. All other sets keep their ranks.
- R6: After every update, the ranks of each set are all distinct and so form a permutation of 0 to WAYS-1.
- R7: With no invalid way flagged, `victim_way_o` is the way of the queried set whose rank is 0. The search runs from the highest way number down.
- R8: Queries are combinational on stored state. In the cycle of a touch to the queried set, `query_ranks_o` and `victim_way_o` still show the order from before that touch.
- R9: When USE_INVALID_MASK is set and `invalid_mask_i` (bit w = way w empty) is nonzero, `victim_way_o` is the lowest-numbered flagged way, whatever the ranks.
- R10: With `touch_valid_i` low, the set and way inputs have no effect on any rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous return of all sets to the initial order |
| touch_valid_i | input | 1 | A touch is presented this cycle |
| touch_set_i | input | SET_W | Set index of the touch |
| touch_way_i | input | RANK_W | Way index of the touch |
| query_set_i | input | SET_W | Set index of the query |
| invalid_mask_i | input | WAYS | Ways of the queried set that hold no line |
| query_ranks_o | output | WAYS*RANK_W | Current ranks of the queried set, way 0 in the low bits |
| victim_way_o | output | RANK_W | Way to replace in the queried set |

## Verification
The victim properties assume that the caller drives `query_set_i` and `invalid_mask_i` stably through each cycle and that every index is inside the parameter range. The bench drives all inputs on the falling edge and draws set and way numbers only from ranges of the parameter size. The rank-tracking properties compare a set's order with the cycle before only when the same set is touched twice in a row. The bench deliberately issues back-to-back touches to one set so that this case arises often, mixed with touches that move between sets.

// File: rtl/lru_rank_pkg.sv
`timescale 1ns/1ps
package lru_rank_pkg;

   parameter int unsigned DEF_SETS = 16;
   parameter int unsigned DEF_WAYS = 4;

   // where the replacement choice came from
   typedef enum logic [0:0] {
      VSRC_RANK    = 1'b0,
      VSRC_INVALID = 1'b1
   } victim_src_e;

   // true when n is a power of two and at least two
   function automatic bit is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/lru_rank_update.sv
`timescale 1ns/1ps
module lru_rank_update #(
   parameter int WAYS   = 4,
   parameter int RANK_W = 2
) (
   input  logic [WAYS*RANK_W-1:0] cur_i,
   input  logic [RANK_W-1:0]      way_i,
   output logic [WAYS*RANK_W-1:0] next_o
);

   localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(WAYS - 1);

   logic [RANK_W-1:0] hit_rank;

   always_comb begin
      hit_rank = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_i == RANK_W'(w)) hit_rank = cur_i[w*RANK_W +: RANK_W];
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [RANK_W-1:0] own;
      assign own = cur_i[w*RANK_W +: RANK_W];
      always_comb begin
         if (way_i == RANK_W'(w)) begin
            next_o[w*RANK_W +: RANK_W] = TOP_RANK;
         end else if (own > hit_rank) begin
            next_o[w*RANK_W +: RANK_W] = own - RANK_W'(1);
         end else begin
            next_o[w*RANK_W +: RANK_W] = own;
         end
      end
   end

endmodule

// File: rtl/lru_victim_pick.sv
`timescale 1ns/1ps
module lru_victim_pick
   import lru_rank_pkg::*;
#(
   parameter int WAYS             = 4,
   parameter int RANK_W           = 2,
   parameter bit USE_INVALID_MASK = 1'b1
) (
   input  logic [WAYS*RANK_W-1:0] ranks_i,
   input  logic [WAYS-1:0]        invalid_mask_i,
   output logic [RANK_W-1:0]      victim_o
);

   logic [WAYS-1:0]   zero_hit;
   logic [RANK_W-1:0] rank_way;
   logic              rank_found;

   for (genvar w = 0; w < WAYS; w++) begin : g_zero
      assign zero_hit[w] = (ranks_i[w*RANK_W +: RANK_W] == '0);
   end

   // search from the top way downward
   always_comb begin
      rank_way   = '0;
      rank_found = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!rank_found && zero_hit[w]) begin
            rank_way   = RANK_W'(w);
            rank_found = 1'b1;
         end
      end
   end

   if (USE_INVALID_MASK) begin : g_mask
      logic [RANK_W-1:0] empty_way;
      victim_src_e       src;

      always_comb begin
         empty_way = '0;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (invalid_mask_i[w]) empty_way = RANK_W'(w);
         end
      end

      assign src      = (|invalid_mask_i) ? VSRC_INVALID : VSRC_RANK;
      assign victim_o = (src == VSRC_INVALID) ? empty_way : rank_way;
   end else begin : g_nomask
      logic unused_mask;
      assign unused_mask = ^invalid_mask_i;
      assign victim_o    = rank_way;
   end

endmodule

// File: rtl/lru_rank_store.sv
`timescale 1ns/1ps
module lru_rank_store #(
   parameter int NUM_SETS = 16,
   parameter int WAYS     = 4,
   parameter int RANK_W   = 2,
   parameter int SET_W    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear_i,
   input  logic                   wr_en_i,
   input  logic [SET_W-1:0]       wr_set_i,
   input  logic [WAYS*RANK_W-1:0] wr_ranks_i,
   input  logic [SET_W-1:0]       rd_a_set_i,
   output logic [WAYS*RANK_W-1:0] rd_a_ranks_o,
   input  logic [SET_W-1:0]       rd_b_set_i,
   output logic [WAYS*RANK_W-1:0] rd_b_ranks_o
);

   localparam int ROW_W = WAYS * RANK_W;

   function automatic logic [ROW_W-1:0] start_order();
      logic [ROW_W-1:0] v;
      for (int w = 0; w < WAYS; w++) v[w*RANK_W +: RANK_W] = RANK_W'(w);
      return v;
   endfunction

   localparam logic [ROW_W-1:0] START_ROW = start_order();

   logic [ROW_W-1:0] rows [NUM_SETS];

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic [ROW_W-1:0] row_q;
      logic             sel;
      assign sel = wr_en_i && (wr_set_i == SET_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_q <= START_ROW;
         end else if (clear_i) begin
            row_q <= START_ROW;
         end else if (sel) begin
            row_q <= wr_ranks_i;
         end
      end
      assign rows[s] = row_q;
   end

   assign rd_a_ranks_o = rows[rd_a_set_i];
   assign rd_b_ranks_o = rows[rd_b_set_i];

endmodule

// File: rtl/lru_rank_tracker.sv
`timescale 1ns/1ps
module lru_rank_tracker
   import lru_rank_pkg::*;
#(
   parameter int NUM_SETS         = DEF_SETS,
   parameter int WAYS             = DEF_WAYS,
   parameter bit USE_INVALID_MASK = 1'b1,
   localparam int SET_W           = $clog2(NUM_SETS),
   localparam int RANK_W          = $clog2(WAYS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear_i,
   input  logic                   touch_valid_i,
   input  logic [SET_W-1:0]       touch_set_i,
   input  logic [RANK_W-1:0]      touch_way_i,
   input  logic [SET_W-1:0]       query_set_i,
   input  logic [WAYS-1:0]        invalid_mask_i,
   output logic [WAYS*RANK_W-1:0] query_ranks_o,
   output logic [RANK_W-1:0]      victim_way_o
);

   if (!is_pow2(NUM_SETS)) begin : g_bad_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (!is_pow2(WAYS)) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end

   logic [WAYS*RANK_W-1:0] touched_ranks;
   logic [WAYS*RANK_W-1:0] touched_next;

   lru_rank_store #(
      .NUM_SETS (NUM_SETS),
      .WAYS     (WAYS),
      .RANK_W   (RANK_W),
      .SET_W    (SET_W)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (clear_i),
      .wr_en_i      (touch_valid_i),
      .wr_set_i     (touch_set_i),
      .wr_ranks_i   (touched_next),
      .rd_a_set_i   (query_set_i),
      .rd_a_ranks_o (query_ranks_o),
      .rd_b_set_i   (touch_set_i),
      .rd_b_ranks_o (touched_ranks)
   );

   lru_rank_update #(
      .WAYS   (WAYS),
      .RANK_W (RANK_W)
   ) u_update (
      .cur_i  (touched_ranks),
      .way_i  (touch_way_i),
      .next_o (touched_next)
   );

   lru_victim_pick #(
      .WAYS             (WAYS),
      .RANK_W           (RANK_W),
      .USE_INVALID_MASK (USE_INVALID_MASK)
   ) u_pick (
      .ranks_i        (query_ranks_o),
      .invalid_mask_i (invalid_mask_i),
      .victim_o       (victim_way_o)
   );

endmodule

// File: rtl/lru_rank_checker.sv
`timescale 1ns/1ps
module lru_rank_checker #(
   parameter int NUM_SETS         = 16,
   parameter int WAYS             = 4,
   parameter bit USE_INVALID_MASK = 1'b1,
   localparam int SET_W           = $clog2(NUM_SETS),
   localparam int RANK_W          = $clog2(WAYS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   clear_i,
   input logic                   touch_valid_i,
   input logic [SET_W-1:0]       touch_set_i,
   input logic [RANK_W-1:0]      touch_way_i,
   input logic [SET_W-1:0]       query_set_i,
   input logic [WAYS-1:0]        invalid_mask_i,
   input logic [WAYS*RANK_W-1:0] query_ranks_i,
   input logic [RANK_W-1:0]      victim_way_i,
   input logic [WAYS*RANK_W-1:0] touched_ranks_i
);

   localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(WAYS - 1);

   function automatic logic [WAYS*RANK_W-1:0] start_order();
      logic [WAYS*RANK_W-1:0] v;
      for (int w = 0; w < WAYS; w++) v[w*RANK_W +: RANK_W] = RANK_W'(w);
      return v;
   endfunction
   localparam logic [WAYS*RANK_W-1:0] START_ROW = start_order();

   // rank values seen in a row
   function automatic logic [WAYS-1:0] seen(input logic [WAYS*RANK_W-1:0] row);
      logic [WAYS-1:0] s;
      s = '0;
      for (int w = 0; w < WAYS; w++) s[row[w*RANK_W +: RANK_W]] = 1'b1;
      return s;
   endfunction

   logic                   prev_touch_q;
   logic                   prev_clear_q;
   logic                   prev_top_q;
   logic [SET_W-1:0]       prev_set_q;
   logic [RANK_W-1:0]      prev_way_q;
   logic [WAYS*RANK_W-1:0] prev_row_q;
   logic [RANK_W-1:0]      touch_way_rank;
   logic [RANK_W-1:0]      prev_way_rank_now;
   logic [RANK_W-1:0]      victim_rank;
   logic [WAYS-1:0]        below_victim;

   assign touch_way_rank    = touched_ranks_i[touch_way_i*RANK_W +: RANK_W];
   assign prev_way_rank_now = touched_ranks_i[prev_way_q*RANK_W +: RANK_W];
   assign victim_rank       = query_ranks_i[victim_way_i*RANK_W +: RANK_W];
   assign below_victim      = invalid_mask_i & ((WAYS'(1) << victim_way_i) - WAYS'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_touch_q <= 1'b0;
         prev_clear_q <= 1'b0;
         prev_top_q   <= 1'b0;
         prev_set_q   <= '0;
         prev_way_q   <= '0;
         prev_row_q   <= '0;
      end else begin
         prev_touch_q <= touch_valid_i && !clear_i;
         prev_clear_q <= clear_i;
         prev_top_q   <= touch_way_rank == TOP_RANK;
         prev_set_q   <= touch_set_i;
         prev_way_q   <= touch_way_i;
         prev_row_q   <= touched_ranks_i;
      end
   end

   assert_clear_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prev_clear_q |-> query_ranks_i == START_ROW);

   assert_top_touch_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_touch_q && prev_top_q && touch_set_i == prev_set_q) |-> touched_ranks_i == prev_row_q);

   assert_touched_newest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_touch_q && touch_set_i == prev_set_q) |-> prev_way_rank_now == TOP_RANK);

   assert_query_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(seen(query_ranks_i)) == WAYS);

   assert_touched_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(seen(touched_ranks_i)) == WAYS);

   assert_victim_rank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!USE_INVALID_MASK || invalid_mask_i == '0) |-> victim_rank == '0);

   assert_victim_empty_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_INVALID_MASK && invalid_mask_i != '0) |->
         (invalid_mask_i[victim_way_i] && below_victim == '0));

   logic unused_query;
   assign unused_query = ^query_set_i;

endmodule

bind lru_rank_tracker lru_rank_checker #(
   .NUM_SETS         (NUM_SETS),
   .WAYS             (WAYS),
   .USE_INVALID_MASK (USE_INVALID_MASK)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .clear_i         (clear_i),
   .touch_valid_i   (touch_valid_i),
   .touch_set_i     (touch_set_i),
   .touch_way_i     (touch_way_i),
   .query_set_i     (query_set_i),
   .invalid_mask_i  (invalid_mask_i),
   .query_ranks_i   (query_ranks_o),
   .victim_way_i    (victim_way_o),
   .touched_ranks_i (touched_ranks)
);

// File: tb/lru_rank_tracker_tb.sv
`timescale 1ns/1ps
module lru_rank_tracker_tb;

   localparam int SETS = 16;
   localparam int WAYS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clear_i = 1'b0;
   logic       touch_valid_i = 1'b0;
   logic [3:0] touch_set_i = '0;
   logic [1:0] touch_way_i = '0;
   logic [3:0] query_set_i = '0;
   logic [3:0] invalid_mask_i = '0;
   logic [7:0] query_ranks_o;
   logic [1:0] victim_way_o;

   always #2 clk = ~clk;

   lru_rank_tracker #(.NUM_SETS(SETS), .WAYS(WAYS), .USE_INVALID_MASK(1'b1)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .clear_i        (clear_i),
      .touch_valid_i  (touch_valid_i),
      .touch_set_i    (touch_set_i),
      .touch_way_i    (touch_way_i),
      .query_set_i    (query_set_i),
      .invalid_mask_i (invalid_mask_i),
      .query_ranks_o  (query_ranks_o),
      .victim_way_o   (victim_way_o)
   );

   typedef struct {
      logic [7:0] ranks;
      logic [1:0] victim;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   mdl [SETS][WAYS];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   function automatic void mdl_start();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) mdl[s][w] = w;
   endfunction

   function automatic void mdl_touch(int s, int w);
      int r;
      r = mdl[s][w];
      for (int k = 0; k < WAYS; k++) if (mdl[s][k] > r) mdl[s][k]--;
      mdl[s][w] = WAYS - 1;
   endfunction

   function automatic logic [7:0] mdl_pack(int s);
      logic [7:0] v;
      for (int w = 0; w < WAYS; w++) v[w*2 +: 2] = 2'(mdl[s][w]);
      return v;
   endfunction

   function automatic logic [1:0] mdl_victim(int s, logic [3:0] mask);
      if (mask != 0) begin
         for (int w = 0; w < WAYS; w++) if (mask[w]) return 2'(w);
      end
      for (int w = WAYS - 1; w >= 0; w--) if (mdl[s][w] == 0) return 2'(w);
      return 2'd0;
   endfunction

   // driver: presents one cycle of inputs and queues the outputs expected in it
   task automatic drive(bit tv, int ts, int tw, bit clr, int qs, logic [3:0] mask, string tag);
      exp_t e;
      @(negedge clk);
      touch_valid_i  = tv;
      touch_set_i    = 4'(ts);
      touch_way_i    = 2'(tw);
      clear_i        = clr;
      query_set_i    = 4'(qs);
      invalid_mask_i = mask;
      e.ranks  = mdl_pack(qs);
      e.victim = mdl_victim(qs, mask);
      e.tag    = tag;
      q.push_back(e);
      if (clr || !rst_n) mdl_start();
      else if (tv) mdl_touch(ts, tw);
   endtask

   task automatic query(int qs, string tag);
      drive(1'b0, 0, 0, 1'b0, qs, 4'h0, tag);
   endtask

   // monitor: compares outputs before the next rising edge
   initial begin
      exp_t e;
      logic [3:0] seen;
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            n_checks++;
            if (query_ranks_o !== e.ranks) begin
               n_fail++;
               $display("FAIL %s ranks actual %h expected %h", e.tag, query_ranks_o, e.ranks);
            end
            n_checks++;
            if (victim_way_o !== e.victim) begin
               n_fail++;
               $display("FAIL %s victim actual %0d expected %0d", e.tag, victim_way_o, e.victim);
            end
            seen = '0;
            for (int w = 0; w < WAYS; w++) seen[query_ranks_o[w*2 +: 2]] = 1'b1;
            n_checks++;
            if (seen !== 4'hF) begin
               n_fail++;
               $display("FAIL R6 distinct ranks actual %h expected all of 0..3", query_ranks_o);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      mdl_start();
      // R1: held in reset
      query(5, "R1 during reset");
      query(0, "R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      for (int s = 0; s < SETS; s++) query(s, "R1 after reset");

      // R4: touch rank 0 way, then R8 same-cycle query sees old order
      drive(1'b1, 2, 0, 1'b0, 2, 4'h0, "R8 pre-touch view");
      query(2, "R4 touched way newest");
      // R3: touch the way that is already newest
      drive(1'b1, 2, 0, 1'b0, 2, 4'h0, "R3 top touch");
      query(2, "R3 unchanged");
      // R4: middle rank
      drive(1'b1, 2, 2, 1'b0, 3, 4'h0, "R4 mid rank");
      query(2, "R4 mid rank result");
      drive(1'b1, 2, 1, 1'b0, 2, 4'h0, "R8 pre view");
      query(2, "R4 second mid");
      // R5: neighbours untouched
      query(1, "R5 neighbour");
      query(3, "R5 neighbour");
      // R10: stray set and way with valid low
      drive(1'b0, 2, 3, 1'b0, 2, 4'h0, "R10 idle");
      query(2, "R10 unchanged");
      // R9: invalid mask priority
      drive(1'b0, 0, 0, 1'b0, 2, 4'b1010, "R9 lowest empty");
      drive(1'b0, 0, 0, 1'b0, 2, 4'b1000, "R9 single empty");
      drive(1'b0, 0, 0, 1'b0, 2, 4'b1111, "R9 all empty");
      // R7: victim after more touches
      drive(1'b1, 7, 3, 1'b0, 7, 4'h0, "R7 victim");
      drive(1'b1, 7, 0, 1'b0, 7, 4'h0, "R7 victim");
      query(7, "R7 victim after touches");
      // R2: clear, and clear winning over a touch
      drive(1'b1, 7, 1, 1'b1, 7, 4'h0, "R2 clear cycle");
      query(7, "R2 after clear");
      query(2, "R2 after clear");

      // mixed traffic
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         int ts, tw, qs;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ts = (lfsr[2:0] == 3'd0) ? int'(lfsr[7:4]) : int'(lfsr[5]);
         tw = int'(lfsr[9:8]);
         qs = lfsr[11] ? ts : int'(lfsr[15:12]);
         drive(lfsr[3] | lfsr[6], ts, tw, (i % 97) == 96, qs,
               lfsr[14:13] == 2'b11 ? lfsr[3:0] : 4'h0, "R4 R7 mixed");
      end
      query(0, "R6 final");
      query(1, "R6 final");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule